// File: doc/BRIEF.md
# Prescaled Edge Capture Unit

This block records the value of a free-running timer at the moment a chosen event happens on an asynchronous input pin. The pin first passes through a synchronizer, then an edge detector. A small prescaler can make the unit wait for several rising edges before it records anything. When a capture event occurs, the timer value is copied into a capture register and an interrupt flag is raised. The flag stays raised until a one-cycle clear strobe lowers it.

A 4-bit mode input selects the behaviour. The unit can capture on every falling edge, on every rising edge, on every fourth rising edge or on every sixteenth rising edge. The all-zero code switches the unit off and returns its state to the reset values. Any other code holds the outputs and takes no captures. Selecting which timer drives the unit is done outside the block.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, `capture_o` is 0 and `flag_o` is 0.
- R2: The pin passes through a 2-flop synchronizer. Suppose a pin transition is stable before clock edge k. The capture it causes then takes place at edge k+2 and loads the `timer_i` value present at that edge.
- R3: Mode 4'b0101 captures on every rising edge of the pin. Falling edges cause no capture.
- R4: Mode 4'b0011 behaves exactly like mode 4'b0101.
- R5: Mode 4'b0100 captures on every falling edge of the pin. Rising edges cause no capture.
- R6: Mode 4'b0110 captures on every 4th rising edge. The first three rising edges leave `flag_o` and `capture_o` unchanged.
- R7: Mode 4'b0111 captures on every 16th rising edge. The first fifteen rising edges leave the outputs unchanged.
- R8: Any change of the mode clears the prescaler count. After a change, the first capture needs a full new count of rising edges.
- R9: Mode 4'b0000 clears `capture_o`, `flag_o` and the prescaler count on the next clock edge.
- R10: `flag_o` stays at 1 until `clr_i` is high at a clock edge. It then reads 0, and `capture_o` keeps its value.
- R11: A capture and a clear in the same cycle leave `flag_o` at 1.
- R12: The codes that are not capture codes (for example 4'b0010 or 4'b1000) take no captures. They also keep `capture_o` and `flag_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 4 | Capture mode code |
| pin_i | input | 1 | Asynchronous event pin |
| timer_i | input | TIMER_W (16) | Timer value to record |
| clr_i | input | 1 | Flag clear strobe |
| capture_o | output | TIMER_W (16) | Last captured timer value |
| flag_o | output | 1 | Capture interrupt flag |

## Verification
The bench builds the unit with its default parameters: a 16-bit timer, two synchronizer stages, and prescale divisors of 4 and 16. With these values, a full sixteen-edge prescale cycle finishes in a few hundred clock cycles. That is short enough to step through every count, and to change the mode in the middle of a count, one edge at a time. The two-stage synchronizer gives a fixed latency of two clock edges. The bench samples at that point, so each capture can be tied to one timer value that the bench set on purpose.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        K_NONE,
        K_FALL,
        K_RISE1,
        K_RISE_A,
        K_RISE_B
    } cap_kind_e;

    localparam logic [3:0] MODE_OFF      = 4'b0000;
    localparam logic [3:0] MODE_RISE_ALT = 4'b0011;
    localparam logic [3:0] MODE_FALL     = 4'b0100;
    localparam logic [3:0] MODE_RISE     = 4'b0101;
    localparam logic [3:0] MODE_RISE_A   = 4'b0110;
    localparam logic [3:0] MODE_RISE_B   = 4'b0111;

    function automatic cap_kind_e decode_mode(input logic [3:0] m);
        case (m)
            MODE_FALL:               return K_FALL;
            MODE_RISE, MODE_RISE_ALT: return K_RISE1;
            MODE_RISE_A:             return K_RISE_A;
            MODE_RISE_B:             return K_RISE_B;
            default:                 return K_NONE;
        endcase
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] s_d, s_q;

    always_comb begin
        s_d = {s_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/cap_prescale.sv
module cap_prescale
    import cap_pkg::*;
#(
    parameter int DIV_A = 4,
    parameter int DIV_B = 16
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] mode_i,
    input  logic       sync_i,
    output logic       rise_o,
    output logic       evt_o
);
    localparam int CNT_W = (DIV_B > 2) ? $clog2(DIV_B) : 1;
    localparam logic [CNT_W-1:0] LIM_A = CNT_W'(DIV_A - 1);
    localparam logic [CNT_W-1:0] LIM_B = CNT_W'(DIV_B - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [3:0]       mode;
        logic             prev;
    } ps_state_t;

    ps_state_t st_d, st_q;
    cap_kind_e kind;
    logic      rise, fall, changed;
    logic [CNT_W-1:0] lim;

    always_comb begin
        kind    = decode_mode(mode_i);
        rise    = sync_i & ~st_q.prev;
        fall    = ~sync_i & st_q.prev;
        changed = (mode_i != st_q.mode);
        lim     = (kind == K_RISE_A) ? LIM_A : LIM_B;
        st_d      = st_q;
        st_d.prev = sync_i;
        st_d.mode = mode_i;
        evt_o     = 1'b0;
        if (changed || kind == K_NONE || kind == K_FALL || kind == K_RISE1) begin
            st_d.cnt = '0;
            if (!changed)
                evt_o = (kind == K_FALL && fall) || (kind == K_RISE1 && rise);
        end else if (rise) begin
            if (st_q.cnt == lim) begin
                evt_o    = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rise_o = rise;
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter int TIMER_W     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int DIV_A       = 4,
    parameter int DIV_B       = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [3:0]         mode_i,
    input  logic               pin_i,
    input  logic [TIMER_W-1:0] timer_i,
    input  logic               clr_i,
    output logic [TIMER_W-1:0] capture_o,
    output logic               flag_o
);
    typedef struct packed {
        logic [TIMER_W-1:0] cap;
        logic               flag;
    } top_state_t;

    top_state_t st_d, st_q;
    logic pin_sync, cap_evt, edge_rise;

    cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(pin_sync)
    );

    cap_prescale #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_ps (
        .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .sync_i(pin_sync),
        .rise_o(edge_rise), .evt_o(cap_evt)
    );

    always_comb begin
        st_d = st_q;
        if (mode_i == MODE_OFF) begin
            st_d = '0;
        end else if (cap_evt) begin
            st_d.cap  = timer_i;
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign capture_o = st_q.cap;
    assign flag_o    = st_q.flag;
endmodule

// File: rtl/edge_capture_chk.sv
module edge_capture_chk #(
    parameter int TIMER_W = 16
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [3:0]         mode_i,
    input logic               clr_i,
    input logic [TIMER_W-1:0] timer_i,
    input logic [TIMER_W-1:0] capture_o,
    input logic               flag_o,
    input logic               evt,
    input logic               rise
);
    // R2
    evt_loads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt && mode_i != 4'b0000) |=> (flag_o && capture_o == $past(timer_i)));
    // R9
    off_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_i == 4'b0000) |=> (!flag_o && capture_o == '0));
    // R10
    clear_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !evt) |=> !flag_o);
    // R12
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!evt && !clr_i && mode_i != 4'b0000) |=> ($stable(capture_o) && $stable(flag_o)));
    // R12
    no_evt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt |-> (mode_i inside {4'b0011, 4'b0100, 4'b0101, 4'b0110, 4'b0111}));
    // R6
    div_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt && mode_i inside {4'b0110, 4'b0111}) |-> rise);
endmodule

bind edge_capture_unit edge_capture_chk #(.TIMER_W(TIMER_W)) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .clr_i(clr_i),
    .timer_i(timer_i), .capture_o(capture_o), .flag_o(flag_o),
    .evt(cap_evt), .rise(edge_rise)
);

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  mode = 4'b0000;
    logic        pin = 1'b0;
    logic [15:0] timer = 16'h0000;
    logic        clr = 1'b0;
    logic [15:0] cap;
    logic        flag;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    edge_capture_unit uut (
        .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .pin_i(pin),
        .timer_i(timer), .clr_i(clr), .capture_o(cap), .flag_o(flag)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic set_pin(input logic v, input logic [15:0] t);
        @(negedge clk);
        timer = t;
        pin = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        @(negedge clk);
        mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 capture", {16'h0, cap}, 32'h0);
        check("R1 flag", {31'h0, flag}, 32'h0);
    endtask

    task automatic t_latency();
        set_mode(4'b0101);
        @(negedge clk);
        timer = 16'h1111;
        pin = 1'b1;
        @(negedge clk); timer = 16'h2222;
        @(negedge clk); timer = 16'h3333;
        @(negedge clk); timer = 16'h4444;
        check("R2 capture at edge k+2", {16'h0, cap}, 32'h3333);
        check("R2 flag", {31'h0, flag}, 32'h1);
        set_pin(1'b0, 16'h5555);
    endtask

    task automatic t_rise(input logic [3:0] m, input string req);
        set_mode(m);
        do_clear();
        set_pin(1'b1, 16'hA001);
        check({req, " rise cap"}, {16'h0, cap}, 32'hA001);
        do_clear();
        set_pin(1'b0, 16'hA002);
        check({req, " falling ignored"}, {31'h0, flag}, 32'h0);
        check({req, " cap kept"}, {16'h0, cap}, 32'hA001);
        set_pin(1'b1, 16'hA003);
        check({req, " second rise"}, {16'h0, cap}, 32'hA003);
        set_pin(1'b0, 16'hA004);
    endtask

    task automatic t_fall();
        set_mode(4'b0100);
        do_clear();
        set_pin(1'b1, 16'hB001);
        check("R5 rising ignored", {31'h0, flag}, 32'h0);
        set_pin(1'b0, 16'hB002);
        check("R5 fall cap", {16'h0, cap}, 32'hB002);
        check("R5 fall flag", {31'h0, flag}, 32'h1);
    endtask

    task automatic t_div(input logic [3:0] m, input int n, input string req);
        set_mode(m);
        do_clear();
        for (int i = 1; i < n; i++) begin
            set_pin(1'b1, 16'(16'hC000 + i));
            set_pin(1'b0, 16'h0);
        end
        check({req, " no flag before count"}, {31'h0, flag}, 32'h0);
        set_pin(1'b1, 16'hCEEE);
        check({req, " cap on last edge"}, {16'h0, cap}, 32'hCEEE);
        check({req, " flag on last edge"}, {31'h0, flag}, 32'h1);
        set_pin(1'b0, 16'h0);
    endtask

    task automatic t_change();
        set_mode(4'b0111);
        do_clear();
        for (int i = 0; i < 3; i++) begin
            set_pin(1'b1, 16'hD000);
            set_pin(1'b0, 16'h0);
        end
        set_mode(4'b0110);
        for (int i = 0; i < 3; i++) begin
            set_pin(1'b1, 16'hD100);
            set_pin(1'b0, 16'h0);
        end
        check("R8 count restarted", {31'h0, flag}, 32'h0);
        set_pin(1'b1, 16'hD222);
        check("R8 full count capture", {16'h0, cap}, 32'hD222);
        set_pin(1'b0, 16'h0);
    endtask

    task automatic t_off();
        set_mode(4'b0000);
        check("R9 capture cleared", {16'h0, cap}, 32'h0);
        check("R9 flag cleared", {31'h0, flag}, 32'h0);
    endtask

    task automatic t_clear();
        set_mode(4'b0101);
        set_pin(1'b1, 16'hE001);
        set_pin(1'b0, 16'h0);
        repeat (5) @(negedge clk);
        check("R10 flag held", {31'h0, flag}, 32'h1);
        do_clear();
        check("R10 flag cleared", {31'h0, flag}, 32'h0);
        check("R10 cap kept", {16'h0, cap}, 32'hE001);
    endtask

    task automatic t_both();
        @(negedge clk);
        timer = 16'hF00F;
        pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R11 capture wins", {31'h0, flag}, 32'h1);
        check("R11 cap", {16'h0, cap}, 32'hF00F);
        set_pin(1'b0, 16'h0);
    endtask

    task automatic t_other();
        set_mode(4'b0010);
        set_pin(1'b1, 16'h7777);
        check("R12 flag held in 0010", {31'h0, flag}, 32'h1);
        check("R12 cap held in 0010", {16'h0, cap}, 32'hF00F);
        set_pin(1'b0, 16'h0);
        set_mode(4'b1000);
        do_clear();
        set_pin(1'b1, 16'h8888);
        check("R12 no capture in 1000", {31'h0, flag}, 32'h0);
        check("R12 cap held in 1000", {16'h0, cap}, 32'hF00F);
        set_pin(1'b0, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_rise(4'b0101, "R3");
        t_rise(4'b0011, "R4");
        t_fall();
        t_div(4'b0110, 4, "R6");
        t_div(4'b0111, 16, "R7");
        t_change();
        t_off();
        t_clear();
        t_both();
        t_other();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule